// File: doc/BRIEF.md
# Table-Driven Byte Matcher with XOR-Folded Sparse Transitions

This block walks a string-matching automaton over a byte stream, taking one byte on each clock where the input is marked valid. The transition function lives in two tables. The first table, the fallback table, is indexed by the byte. It gives the transition the automaton would take from its idle state. The second table, the sparse table, holds only the transitions that differ from that fallback. Each sparse entry is stamped with the state that owns it. Entries from different states overlap in one array, and each state reaches its entries by XOR-ing its own base address with the byte. A fetched sparse entry is used only when its owner stamp equals the current state. Otherwise the fallback entry for that byte is used.

Every entry in both tables holds the next state together with that state's base address. As a result the state register always carries the base address that the next lookup needs. A third table, the decoder, maps the registered state to a match vector, so the output is Moore-style. All three tables are loaded by the surrounding system through synchronous write ports while the stream is paused. A restore input puts the automaton back in its idle state, for example at a packet boundary. Several instances, one per byte lane, can feed a combining stage that finds strings spread across lanes.

Top module: `pm_matcher`

## Requirements
- R1: While reset is high and on the first cycle after it, `state_o` is the idle state (0) and `match_o` is all zeros.
- R2: On a valid byte, when the sparse entry fetched for that byte is stamped with a state other than the current one, the next state and base come from the fallback entry at address = byte. The fallback word layout is {state[17:10], base[9:0]}.
- R3: On a valid byte, when the fetched sparse entry's stamp equals the current state, the next state and base come from that sparse entry. The sparse word layout is {stamp[25:18], state[17:10], base[9:0]}.
- R4: The sparse address is the 10-bit base XOR the zero-extended byte. The upper 2 base bits pick a 256-entry page and the lower 8 bits permute offsets within it. The sum base+byte is never used as the address.
- R5: The base address stored with the selected entry is the one used for the lookup of the next valid byte.
- R6: `match_o` always equals the decoder entry of the state currently shown on `state_o`, and both change on the same clock edge.
- R7: With valid low and restore low, `state_o` and `match_o` hold their values.
- R8: Restore loads the idle state (0) with idle base 0, takes priority over a valid byte in the same cycle, and updates `match_o` to the decoder entry of the idle state.
- R9: Table writes take effect at the clock edge where the write enable is high, leave the state untouched, and are only issued while valid is low.
- R10: A sparse entry carrying the reserved stamp 255, or another state's stamp, never supplies a transition, so the automaton never enters state 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restore_i | input | 1 | Return to the idle state |
| in_valid_i | input | 1 | Input byte is valid this cycle |
| in_byte_i | input | 8 | Input byte |
| dflt_we_i | input | 1 | Fallback table write enable |
| dflt_addr_i | input | 8 | Fallback table write address |
| dflt_wdata_i | input | 18 | Fallback table write word {state, base} |
| pk_we_i | input | 1 | Sparse table write enable |
| pk_addr_i | input | 10 | Sparse table write address |
| pk_wdata_i | input | 26 | Sparse table write word {stamp, state, base} |
| dec_we_i | input | 1 | Decoder table write enable |
| dec_addr_i | input | 8 | Decoder table write address (state) |
| dec_wdata_i | input | 4 | Decoder table write word (match vector) |
| state_o | output | 8 | Registered current state |
| match_o | output | 4 | Registered match vector of the current state |

## Verification
The bench builds the block with its default parameters: an 8-bit state, a 10-bit base, 8-bit bytes and a 4-bit match vector. With these values the sparse array spans four 256-entry pages. The bench places states in pages 0, 1, 2 and 3 with non-zero low base bits, so the XOR permutation, the page selection and the difference between XOR and additive addressing can all be observed at the ports. The loaded automaton also includes an entry stamped by the wrong owner, an entry at the additive address, and a self-loop. These show that only owner-matched entries ever win, as the long mixed stream of bytes, pauses and restores runs against the reference model.

// File: rtl/pm_pkg.sv
package pm_pkg;
  // Default geometry of the byte matcher
  localparam int PM_STATE_W = 8;
  localparam int PM_BASE_W  = 10;
  localparam int PM_IN_W    = 8;
  localparam int PM_MATCH_W = 4;
endpackage

// File: rtl/pm_table_ram.sv
// Synchronous-write, asynchronous-read table (distributed RAM style)
module pm_table_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pm_next_sel.sv
// Chooses between the owner-stamped sparse entry and the fallback entry
module pm_next_sel #(
  parameter int SW = 8,
  parameter int BW = 10
) (
  input  logic [SW-1:0] cur_state,
  input  logic [SW-1:0] pk_tag,
  input  logic [SW-1:0] pk_state,
  input  logic [BW-1:0] pk_base,
  input  logic [SW-1:0] df_state,
  input  logic [BW-1:0] df_base,
  output logic [SW-1:0] nxt_state,
  output logic [BW-1:0] nxt_base
);
  logic owner_hit;

  always_comb begin
    owner_hit = (pk_tag == cur_state);
    if (owner_hit) begin
      nxt_state = pk_state;
      nxt_base  = pk_base;
    end else begin
      nxt_state = df_state;
      nxt_base  = df_base;
    end
  end
endmodule

// File: rtl/pm_matcher.sv
module pm_matcher #(
  parameter int STATE_W    = pm_pkg::PM_STATE_W,
  parameter int BASE_W     = pm_pkg::PM_BASE_W,
  parameter int IN_W       = pm_pkg::PM_IN_W,
  parameter int MATCH_W    = pm_pkg::PM_MATCH_W,
  parameter int IDLE_STATE = 0,
  parameter int IDLE_BASE  = 0,
  parameter int NO_OWNER   = 255
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            restore_i,
  input  logic                            in_valid_i,
  input  logic [IN_W-1:0]                 in_byte_i,
  input  logic                            dflt_we_i,
  input  logic [IN_W-1:0]                 dflt_addr_i,
  input  logic [STATE_W+BASE_W-1:0]       dflt_wdata_i,
  input  logic                            pk_we_i,
  input  logic [BASE_W-1:0]               pk_addr_i,
  input  logic [2*STATE_W+BASE_W-1:0]     pk_wdata_i,
  input  logic                            dec_we_i,
  input  logic [STATE_W-1:0]              dec_addr_i,
  input  logic [MATCH_W-1:0]              dec_wdata_i,
  output logic [STATE_W-1:0]              state_o,
  output logic [MATCH_W-1:0]              match_o
);
  localparam int DF_W = STATE_W + BASE_W;
  localparam int PK_W = STATE_W + DF_W;
  localparam logic [STATE_W-1:0] IDLE_S = STATE_W'(IDLE_STATE);
  localparam logic [BASE_W-1:0]  IDLE_B = BASE_W'(IDLE_BASE);
  localparam logic [STATE_W-1:0] NO_OWN = STATE_W'(NO_OWNER);

  logic [STATE_W-1:0] state_q;
  logic [BASE_W-1:0]  base_q;
  logic [MATCH_W-1:0] match_q;

  logic [BASE_W-1:0]  pk_idx;
  logic [DF_W-1:0]    df_word;
  logic [PK_W-1:0]    pk_word;
  logic [STATE_W-1:0] nxt_state;
  logic [BASE_W-1:0]  nxt_base;
  logic [STATE_W-1:0] dec_raddr;
  logic [MATCH_W-1:0] dec_word;

  // Page select from upper base bits, in-page permutation by XOR
  generate
    if (BASE_W > IN_W) begin : g_paged
      assign pk_idx = {base_q[BASE_W-1:IN_W], base_q[IN_W-1:0] ^ in_byte_i};
    end else begin : g_flat
      assign pk_idx = base_q ^ in_byte_i[BASE_W-1:0];
    end
  endgenerate

  pm_table_ram #(.AW(IN_W), .DW(DF_W)) u_dflt (
    .clk(clk), .we(dflt_we_i), .waddr(dflt_addr_i), .wdata(dflt_wdata_i),
    .raddr(in_byte_i), .rdata(df_word)
  );

  pm_table_ram #(.AW(BASE_W), .DW(PK_W)) u_sparse (
    .clk(clk), .we(pk_we_i), .waddr(pk_addr_i), .wdata(pk_wdata_i),
    .raddr(pk_idx), .rdata(pk_word)
  );

  pm_next_sel #(.SW(STATE_W), .BW(BASE_W)) u_sel (
    .cur_state(state_q),
    .pk_tag   (pk_word[PK_W-1 -: STATE_W]),
    .pk_state (pk_word[DF_W-1 -: STATE_W]),
    .pk_base  (pk_word[BASE_W-1:0]),
    .df_state (df_word[DF_W-1 -: STATE_W]),
    .df_base  (df_word[BASE_W-1:0]),
    .nxt_state(nxt_state),
    .nxt_base (nxt_base)
  );

  // Decoder read at the state about to be registered, so output stays Moore
  assign dec_raddr = restore_i ? IDLE_S : nxt_state;

  pm_table_ram #(.AW(STATE_W), .DW(MATCH_W)) u_dec (
    .clk(clk), .we(dec_we_i), .waddr(dec_addr_i), .wdata(dec_wdata_i),
    .raddr(dec_raddr), .rdata(dec_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= IDLE_S;
      base_q  <= IDLE_B;
      match_q <= '0;
    end else if (restore_i) begin
      state_q <= IDLE_S;
      base_q  <= IDLE_B;
      match_q <= dec_word;
    end else if (in_valid_i) begin
      state_q <= nxt_state;
      base_q  <= nxt_base;
      match_q <= dec_word;
    end
  end

  assign state_o = state_q;
  assign match_o = match_q;

  // R8: restore lands in idle on the next edge
  p_restore_idle_r8: assert property (@(posedge clk) disable iff (rst)
    restore_i |=> (state_o == IDLE_S));

  // R7: paused stream holds state and output
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!restore_i && !in_valid_i) |=> ($stable(state_o) && $stable(match_o)));

  // R9: tables are only written while the stream is paused
  p_wr_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (dflt_we_i || pk_we_i || dec_we_i) |-> !in_valid_i);

  // R10: the reserved owner stamp is never entered as a state
  p_no_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !restore_i) |=> (state_o != NO_OWN));
endmodule

// File: tb/pm_matcher_test.sv
module pm_matcher_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restore_i = 1'b0, in_valid_i = 1'b0;
  logic [7:0]  in_byte_i = '0;
  logic dflt_we_i = 1'b0, pk_we_i = 1'b0, dec_we_i = 1'b0;
  logic [7:0]  dflt_addr_i = '0;
  logic [17:0] dflt_wdata_i = '0;
  logic [9:0]  pk_addr_i = '0;
  logic [25:0] pk_wdata_i = '0;
  logic [7:0]  dec_addr_i = '0;
  logic [3:0]  dec_wdata_i = '0;
  logic [7:0]  state_o;
  logic [3:0]  match_o;

  always #10 clk = ~clk;

  pm_matcher uut (
    .clk(clk), .rst(rst), .restore_i(restore_i), .in_valid_i(in_valid_i),
    .in_byte_i(in_byte_i), .dflt_we_i(dflt_we_i), .dflt_addr_i(dflt_addr_i),
    .dflt_wdata_i(dflt_wdata_i), .pk_we_i(pk_we_i), .pk_addr_i(pk_addr_i),
    .pk_wdata_i(pk_wdata_i), .dec_we_i(dec_we_i), .dec_addr_i(dec_addr_i),
    .dec_wdata_i(dec_wdata_i), .state_o(state_o), .match_o(match_o)
  );

  int checks = 0;
  int failures = 0;

  // Reference model
  logic [17:0] df_m [256];
  logic [25:0] pk_m [1024];
  logic [3:0]  dec_m [256];
  int m_st = 0;
  int m_base = 0;
  logic [3:0] m_match = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp(input string req);
    chk({req, " state"}, int'(state_o), m_st);
    chk({req, " match"}, int'(match_o), int'(m_match));
  endtask

  task automatic wr_df(input int a, input int st, input int b);
    dflt_we_i = 1'b1; dflt_addr_i = 8'(a); dflt_wdata_i = {8'(st), 10'(b)};
    @(posedge clk); df_m[a] = {8'(st), 10'(b)};
    @(negedge clk); dflt_we_i = 1'b0;
  endtask

  task automatic wr_pk(input int a, input int tag, input int st, input int b);
    pk_we_i = 1'b1; pk_addr_i = 10'(a); pk_wdata_i = {8'(tag), 8'(st), 10'(b)};
    @(posedge clk); pk_m[a] = {8'(tag), 8'(st), 10'(b)};
    @(negedge clk); pk_we_i = 1'b0;
  endtask

  task automatic wr_dec(input int a, input int v);
    dec_we_i = 1'b1; dec_addr_i = 8'(a); dec_wdata_i = 4'(v);
    @(posedge clk); dec_m[a] = 4'(v);
    @(negedge clk); dec_we_i = 1'b0;
  endtask

  // Apply one cycle of stream inputs, update the model at the edge
  task automatic step(input logic r, input logic v, input int b);
    restore_i = r; in_valid_i = v; in_byte_i = 8'(b);
    @(posedge clk);
    if (r) begin
      m_st = 0; m_base = 0; m_match = dec_m[0];
    end else if (v) begin
      logic [9:0]  idx;
      logic [25:0] e;
      idx = 10'(m_base) ^ {2'b00, 8'(b)};
      e = pk_m[idx];
      if (int'(e[25:18]) == m_st) begin
        m_st = int'(e[17:10]); m_base = int'(e[9:0]);
      end else begin
        m_st = int'(df_m[b][17:10]); m_base = int'(df_m[b][9:0]);
      end
      m_match = dec_m[m_st];
    end
    @(negedge clk);
    restore_i = 1'b0; in_valid_i = 1'b0;
  endtask

  localparam int B1 = 'h105, B2 = 'h2A3, B3 = 'h3FF, B4 = 'h0C0;
  localparam int CA = 'h61, CT = 'h74, CX = 'h78, CZ = 'h7A;

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R1 reset state", int'(state_o), 0);
    chk("R1 reset match", int'(match_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post-reset state", int'(state_o), 0);
    chk("R1 post-reset match", int'(match_o), 0);

    // Bulk load: fallback to idle, sparse unused, decoder zero
    for (int i = 0; i < 256; i++) wr_df(i, 0, 0);
    for (int i = 0; i < 1024; i++) wr_pk(i, 255, 0, 0);
    for (int i = 0; i < 256; i++) wr_dec(i, 0);
    cmp("R9 writes leave state");

    // Automaton for a t t a with overlaps and decoys
    wr_df(CA, 1, B1);
    wr_pk(B1 ^ CA, 1, 1, B1);
    wr_pk(B1 ^ CT, 1, 2, B2);
    wr_pk(B1 + CT, 1, 6, 0);        // additive address decoy (R4)
    wr_pk(B2 ^ CT, 2, 3, B3);
    wr_pk(B2 ^ CX, 1, 7, 0);        // wrong owner decoy (R10)
    wr_pk(B3 ^ CA, 3, 4, B4);
    wr_pk(B4 ^ CT, 4, 2, B2);
    wr_dec(2, 1); wr_dec(4, 8); wr_dec(6, 4); wr_dec(1, 0);

    step(0, 1, CA);  cmp("R2 fallback from idle");
    chk("R2 state a", int'(state_o), 1);
    step(0, 1, CT);  cmp("R3 owner hit");
    chk("R4 xor addr not sum", int'(state_o), 2);
    chk("R6 match of state 2", int'(match_o), 1);
    step(0, 0, CX);  chk("R7 hold state", int'(state_o), 2);
    chk("R7 hold match", int'(match_o), 1);
    step(0, 1, CT);  chk("R4 page 2 lookup", int'(state_o), 3);
    step(0, 1, CA);  chk("R5 base carried to page 3", int'(state_o), 4);
    chk("R6 match of state 4", int'(match_o), 8);
    step(0, 1, CT);  chk("R5 overlap back to 2", int'(state_o), 2);
    step(0, 1, CX);  chk("R10 wrong owner ignored", int'(state_o), 0);
    chk("R10 match back to idle", int'(match_o), 0);
    step(0, 1, CA);  step(0, 1, CZ);
    chk("R10 unused stamp ignored", int'(state_o), 0);
    step(0, 1, CA);  step(0, 1, CA);
    chk("R3 self loop", int'(state_o), 1);
    step(0, 1, CT);
    step(1, 1, CT);  chk("R8 restore wins over valid", int'(state_o), 0);
    chk("R8 restore match", int'(match_o), 0);
    wr_dec(1, 3);
    chk("R9 decoder write keeps state", int'(state_o), 0);
    step(0, 1, CA);  chk("R9 new decoder value used", int'(match_o), 3);
    cmp("R6 after rewrite");

    // Mixed stream against the model
    lf = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      int b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:0])
        3'd0, 3'd1, 3'd2: b = CA;
        3'd3, 3'd4:       b = CT;
        3'd5:             b = CX;
        3'd6:             b = 'h7C;
        default:          b = int'(lf[15:8]);
      endcase
      step(lf[11:5] == 7'd0, lf[9:8] != 2'b00, b);
      cmp("R5 stream");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule